// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent virtual-to-physical page mappings and translates one virtual address per cycle. The virtual page number is compared against every stored mapping at the same time. On a match, the physical page number is joined with the untouched page offset to form the physical address. Each mapping carries its own read and write permission. It also carries a referenced flag and a modified (dirty) flag, which the block keeps up to date as it is used.

A lookup gets a registered answer one cycle later: hit, miss or protection fault. A miss is only reported. An external handler finds the mapping and installs it through the fill port, and the block chooses the slot. That choice prefers an empty slot, then a slot not referenced since the last sweep. If every slot is referenced, the block clears all referenced flags at once. A single-cycle flush input empties the whole structure.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no slot holds a mapping, rsp_valid is low, and every lookup returns a miss.
- R2: A lookup accepted at a clock edge is answered at the next edge with rsp_valid high and exactly one of rsp_hit, rsp_miss, rsp_fault high; with no lookup all four are low.
- R3: On a hit, rsp_paddr equals the stored physical page number in the upper bits, concatenated with the low OFF_W bits of the lookup address unchanged.
- R4: A lookup whose virtual page number matches no valid slot returns rsp_miss with rsp_paddr zero.
- R5: fill_perm bit 0 grants read and bit 1 grants write. A matching lookup that lacks the needed right returns rsp_fault with rsp_paddr zero, and it leaves the slot's dirty and referenced flags unchanged.
- R6: A permitted hit sets the slot's referenced flag. A permitted write hit also sets its dirty flag. rsp_dirty reports the slot's dirty flag including the current access.
- R7: A fill whose page is not present goes to the lowest-numbered empty slot when one exists.
- R8: When all slots are full, a fill replaces the lowest-numbered slot whose referenced flag is clear.
- R9: When all slots are full and all referenced flags are set, a fill clears every referenced flag and replaces slot 0.
- R10: A fill whose virtual page number is already present overwrites that slot, replacing its physical page and permission and clearing its flags, so no page is ever held twice.
- R11: A flush empties every slot in one cycle. A fill in the same cycle is dropped, and a lookup in the same cycle is answered from the contents before the flush.
- R12: A lookup in the same cycle as a fill sees the contents before the fill. The new mapping is visible from the next cycle.
- R13: A newly filled mapping starts with its referenced and dirty flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | VA_W | Virtual address to translate |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_vpn | input | VPN_W | Virtual page number to install |
| fill_ppn | input | PPN_W | Physical page number to install |
| fill_perm | input | 2 | Rights: bit 0 read, bit 1 write |
| flush | input | 1 | Empty every slot |
| rsp_valid | output | 1 | Registered answer present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No mapping held |
| rsp_fault | output | 1 | Mapping held but access not permitted |
| rsp_dirty | output | 1 | Dirty flag of the hit slot after this access |
| rsp_paddr | output | PA_W | Physical address on hit, zero otherwise |

## Verification
A corrupted valid or tag bit shows at the very next lookup of that page as a wrong hit or miss, one cycle after the request. A wrong dirty flag shows in rsp_dirty on the next hit to that slot. Referenced flags stay invisible until a fill finds every slot occupied, so the tests fill the structure, touch chosen slots and then probe which page was evicted. Same-cycle fill, flush and lookup combinations are driven directly, so that ordering mistakes show up as a wrong answer in the cycle after.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Access rights of one mapping; bit 1 write, bit 0 read.
  typedef struct packed {
    logic wr;
    logic rd;
  } tlb_perm_t;

  function automatic logic perm_allows(tlb_perm_t p, logic is_write);
    return is_write ? p.wr : p.rd;
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [VPN_W-1:0]              key,
  output logic [ENTRIES-1:0]            match,
  output logic                          any,
  output logic [IDX_W-1:0]              idx
);
  // One comparator per slot, all evaluated in parallel.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  assign any = |match;

  // Lowest matching slot wins.
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] refd,
  output logic [IDX_W-1:0]   idx,
  output logic               sweep
);
  logic             have_empty;
  logic             have_cold;
  logic [IDX_W-1:0] empty_idx;
  logic [IDX_W-1:0] cold_idx;

  always_comb begin
    have_empty = 1'b0;
    have_cold  = 1'b0;
    empty_idx  = '0;
    cold_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        have_empty = 1'b1;
        empty_idx  = IDX_W'(i);
      end
      if (valid[i] && !refd[i]) begin
        have_cold = 1'b1;
        cold_idx  = IDX_W'(i);
      end
    end
  end

  // Empty slot first, then unreferenced slot, else sweep and take slot 0.
  assign idx   = have_empty ? empty_idx : (have_cold ? cold_idx : '0);
  assign sweep = !have_empty && !have_cold;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int OFF_W   = 12,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [1:0]       fill_perm,
  input  logic             flush,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic             rsp_dirty,
  output logic [PA_W-1:0]  rsp_paddr
);
  // Slot state.
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0]            ref_q;
  logic [ENTRIES-1:0]            dirty_q;
  tlb_perm_t                     perm_q [ENTRIES];
  logic [PPN_W-1:0]              ppn_mem [ENTRIES];

  // Lookup side.
  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] lk_match;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;
  logic               lk_ok;
  logic               do_hit;
  logic               do_fault;
  logic               do_miss;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off = lk_vaddr[OFF_W-1:0];

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_cam (
    .tags (vpn_q),
    .valid(valid_q),
    .key  (lk_vpn),
    .match(lk_match),
    .any  (lk_any),
    .idx  (lk_idx)
  );

  assign lk_ok    = perm_allows(perm_q[lk_idx], lk_write);
  assign do_hit   = lk_valid && lk_any && lk_ok;
  assign do_fault = lk_valid && lk_any && !lk_ok;
  assign do_miss  = lk_valid && !lk_any;

  // Fill side: duplicate detection, then victim choice.
  logic [ENTRIES-1:0] fill_match;
  logic               fill_dup;
  logic [IDX_W-1:0]   fill_dup_idx;
  logic [IDX_W-1:0]   vic_idx;
  logic               vic_sweep;
  logic               fill_go;
  logic               sweep_go;
  logic [IDX_W-1:0]   fill_slot;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_cam (
    .tags (vpn_q),
    .valid(valid_q),
    .key  (fill_vpn),
    .match(fill_match),
    .any  (fill_dup),
    .idx  (fill_dup_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid(valid_q),
    .refd (ref_q),
    .idx  (vic_idx),
    .sweep(vic_sweep)
  );

  assign fill_go   = fill_valid && !flush;
  assign sweep_go  = fill_go && !fill_dup && vic_sweep;
  assign fill_slot = fill_dup ? fill_dup_idx : vic_idx;

  // Flag and tag update; later assignments take precedence.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      if (sweep_go) ref_q <= '0;
      if (do_hit) begin
        ref_q[lk_idx] <= 1'b1;
        if (lk_write) dirty_q[lk_idx] <= 1'b1;
      end
      if (fill_go) begin
        valid_q[fill_slot] <= 1'b1;
        ref_q[fill_slot]   <= 1'b0;
        dirty_q[fill_slot] <= 1'b0;
      end
    end
  end

  // Payload storage: single write port, no reset.
  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[fill_slot]   <= fill_vpn;
      perm_q[fill_slot]  <= tlb_perm_t'(fill_perm);
      ppn_mem[fill_slot] <= fill_ppn;
    end
  end

  // Registered answer.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= do_hit;
      rsp_miss  <= do_miss;
      rsp_fault <= do_fault;
      rsp_dirty <= do_hit && (dirty_q[lk_idx] || lk_write);
      rsp_paddr <= do_hit ? {ppn_mem[lk_idx], lk_off} : '0;
    end
  end
endmodule

// File: rtl/tlb_xlate_sva.sv
module tlb_xlate_sva #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int OFF_W   = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_valid,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic               flush,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic [ENTRIES-1:0] lk_match,
  input logic [ENTRIES-1:0] valid_q
);
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    $countones({rsp_hit, rsp_miss, rsp_fault}) == (rsp_valid ? 1 : 0));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !rst) |=> rsp_valid);

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

  assert_zero_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_miss || rsp_fault) |-> rsp_paddr == '0);

  assert_no_double_map_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
    flush |=> valid_q == '0);
endmodule

bind tlb_xlate tlb_xlate_sva #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)
) u_sva (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .flush(flush),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .lk_match(lk_match),
  .valid_q(valid_q)
);

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
  localparam int VPN_W = 20;
  localparam int PPN_W = 18;
  localparam int OFF_W = 12;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lk_valid = 1'b0;
  logic             lk_write = 1'b0;
  logic [VA_W-1:0]  lk_vaddr = '0;
  logic             fill_valid = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [1:0]       fill_perm = '0;
  logic             flush = 1'b0;
  logic             rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
  logic [PA_W-1:0]  rsp_paddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Captured answer of the last lookup.
  logic            r_valid, r_hit, r_miss, r_fault, r_dirty;
  logic [PA_W-1:0] r_paddr;

  always #5 clk = ~clk;

  tlb_xlate u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_dirty(rsp_dirty), .rsp_paddr(rsp_paddr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic capture();
    r_valid = rsp_valid; r_hit = rsp_hit; r_miss = rsp_miss;
    r_fault = rsp_fault; r_dirty = rsp_dirty; r_paddr = rsp_paddr;
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] off, input logic wr);
    @(negedge clk);
    lk_valid = 1'b1; lk_write = wr; lk_vaddr = {v, off};
    @(posedge clk); #1;
    lk_valid = 1'b0; lk_write = 1'b0;
    capture();
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input logic [1:0] perm);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_perm = perm;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
  endtask

  // Expect a hit with given physical page; offset comes from the lookup.
  task automatic expect_hit(input string req, input logic [VPN_W-1:0] v,
                            input logic [PPN_W-1:0] p, input logic wr, input logic dirty);
    lookup(v, 12'h5a3, wr);
    check({req, " hit"}, {r_valid, r_hit, r_miss, r_fault}, 4'b1100);
    check({req, " paddr"}, r_paddr, {p, 12'h5a3});
    check({req, " dirty"}, r_dirty, dirty);
  endtask

  task automatic expect_miss(input string req, input logic [VPN_W-1:0] v);
    lookup(v, 12'h0f0, 1'b0);
    check({req, " miss"}, {r_valid, r_hit, r_miss, r_fault}, 4'b1010);
    check({req, " paddr zero"}, r_paddr, '0);
  endtask

  task automatic t_reset();
    check("R1 rsp_valid after reset", rsp_valid, 0);
    expect_miss("R1", 20'h00042);
    @(posedge clk); #1;
    check("R2 idle outputs", {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 4'b0000);
  endtask

  task automatic t_basic();
    fill(20'h12345, 18'h0abcd, 2'b11);
    expect_hit("R3 R13 fresh read", 20'h12345, 18'h0abcd, 1'b0, 1'b0);
    expect_hit("R6 write hit", 20'h12345, 18'h0abcd, 1'b1, 1'b1);
    expect_hit("R6 dirty kept", 20'h12345, 18'h0abcd, 1'b0, 1'b1);
    expect_miss("R4 other page", 20'h12346);
  endtask

  task automatic t_perm();
    fill(20'h00a00, 18'h00111, 2'b01);
    lookup(20'h00a00, 12'h001, 1'b1);
    check("R5 write to read-only faults", {r_valid, r_hit, r_miss, r_fault}, 4'b1001);
    check("R5 fault paddr zero", r_paddr, '0);
    expect_hit("R5 read after fault, dirty untouched", 20'h00a00, 18'h00111, 1'b0, 1'b0);
    fill(20'h00b00, 18'h00222, 2'b10);
    lookup(20'h00b00, 12'h002, 1'b0);
    check("R5 read of write-only faults", {r_hit, r_miss, r_fault}, 3'b001);
    expect_hit("R5 write-only write", 20'h00b00, 18'h00222, 1'b1, 1'b1);
  endtask

  task automatic t_dup();
    fill(20'h00c00, 18'h00333, 2'b11);
    expect_hit("R10 before", 20'h00c00, 18'h00333, 1'b1, 1'b1);
    fill(20'h00c00, 18'h00444, 2'b01);
    expect_hit("R10 overwritten", 20'h00c00, 18'h00444, 1'b0, 1'b0);
    lookup(20'h00c00, 12'h0, 1'b1);
    check("R10 new perm applies", {r_hit, r_fault}, 2'b01);
  endtask

  task automatic t_replace();
    do_flush();
    for (int k = 0; k < 8; k++) fill(20'h00100 + 20'(k), 18'h02000 + 18'(k), 2'b11);
    // R7: eight fills occupied slots in order; all present.
    for (int k = 0; k < 8; k++)
      if (k >= 2) begin
        lookup(20'h00100 + 20'(k), 12'h0, 1'b0);
      end
    // That touched slots 2..7; slots 0 and 1 stay cold.
    fill(20'h00200, 18'h03000, 2'b11);
    expect_miss("R8 lowest cold slot evicted", 20'h00100);
    expect_hit("R8 others kept", 20'h00101, 18'h02001, 1'b0, 1'b0);
    expect_hit("R8 new page", 20'h00200, 18'h03000, 1'b0, 1'b0);
    // Now every slot is referenced.
    fill(20'h00201, 18'h03001, 2'b11);
    expect_miss("R9 sweep evicts slot 0", 20'h00200);
    expect_hit("R9 new page in slot 0", 20'h00201, 18'h03001, 1'b0, 1'b0);
    // Sweep cleared slot 1..7 flags; slot 0 just touched, so slot 1 goes next.
    fill(20'h00202, 18'h03002, 2'b11);
    expect_miss("R9 flags cleared, slot 1 evicted", 20'h00101);
    expect_hit("R9 slot 2 kept", 20'h00102, 18'h02002, 1'b0, 1'b0);
  endtask

  task automatic t_fresh_lowest();
    do_flush();
    fill(20'h00300, 18'h00300, 2'b11);
    fill(20'h00301, 18'h00301, 2'b11);
    fill(20'h00302, 18'h00302, 2'b11);
    do_flush();
    fill(20'h00310, 18'h00310, 2'b11);
    for (int k = 1; k < 8; k++) fill(20'h00320 + 20'(k), 18'h00320, 2'b11);
    // Full, all cold: a fill must take slot 0, the first filled page.
    fill(20'h00330, 18'h00330, 2'b11);
    expect_miss("R7 R13 first page was slot 0", 20'h00310);
    expect_hit("R7 slot 1 kept", 20'h00321, 18'h00320, 1'b0, 1'b0);
  endtask

  task automatic t_same_cycle();
    do_flush();
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h00400; fill_ppn = 18'h00400; fill_perm = 2'b11;
    lk_valid = 1'b1; lk_write = 1'b0; lk_vaddr = {20'h00400, 12'h0};
    @(posedge clk); #1;
    fill_valid = 1'b0; lk_valid = 1'b0;
    capture();
    check("R12 lookup sees old contents", {r_hit, r_miss}, 2'b01);
    expect_hit("R12 visible next cycle", 20'h00400, 18'h00400, 1'b0, 1'b0);
  endtask

  task automatic t_flush();
    fill(20'h00500, 18'h00500, 2'b11);
    @(negedge clk);
    flush = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h00501; fill_ppn = 18'h00501; fill_perm = 2'b11;
    lk_valid = 1'b1; lk_write = 1'b0; lk_vaddr = {20'h00500, 12'h0};
    @(posedge clk); #1;
    flush = 1'b0; fill_valid = 1'b0; lk_valid = 1'b0;
    capture();
    check("R11 lookup in flush cycle uses old contents", r_hit, 1'b1);
    expect_miss("R11 entry gone", 20'h00500);
    expect_miss("R11 fill dropped", 20'h00501);
    expect_miss("R11 older entry gone", 20'h00400);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_basic();
    t_perm();
    t_dup();
    t_replace();
    t_fresh_lowest();
    t_same_cycle();
    t_flush();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule